// File: doc/BRIEF.md
# Masked Latching Alarm Aggregator

This block gathers ten event and status lines into one 10-bit raw word. The raw word is the instantaneous, unlatched view of those lines. Each raw bit that is enabled by a mask register is captured into a sticky status register. An active-low interrupt line is pulled low while any status bit is held. A host reads the raw, status and mask words through a small register port. It rewrites the mask at runtime and acknowledges flags by writing ones to the status address.

Three inputs need handling beyond plain level capture.
- The init-complete line is a one-cycle pulse. It must be caught as a sticky flag.
- The charger-detect line is debounced. Its status bit flags any change of the debounced value against a stored copy, not a level.
- A power-on flag is set by reset and dropped when the configuration-update exit pulse arrives.

Top module: `alarm_agg`

## Requirements
- R1: `alert_n` is 0 in the same cycle that any status bit is 1, and 1 when the status word is zero. The pin is meant to drive an open-drain pad, low when active.
- R2: The raw word packs the lines in this order: bit0 safety-status-A, bit1 safety-status-B, bit2 safety-alert-A, bit3 safety-alert-B, bit4 charge switch off, bit5 discharge switch off, bit6 shutdown voltage, bit7 init-complete, bit8 charger-detect input, bit9 power-on flag. For every bit except 8, a status bit becomes 1 at the clock edge where that raw bit and its mask bit are both 1. A status bit stays 0 when its mask bit is 0.
- R3: A write to address 1 clears each status bit whose data bit is 1. Status bits whose data bit is 0 are unchanged.
- R4: After reset the mask equals parameter `DEF_MASK`. A write to address 2 replaces the mask, and it is read back at address 2.
- R5: Reads are combinational. Address 0 returns the raw word, address 1 the status word, address 2 the mask, and address 3 returns zero.
- R6: A single-cycle pulse on `init_done` with mask bit 7 set leaves status bit 7 at 1 until the host clears it.
- R7: The debounced charger-detect value takes the input's value only after the input has differed from it on `DEB_N` consecutive clock edges. A shorter excursion leaves it unchanged. The debounced value resets to 0.
- R8: While mask bit 8 is 1 and the debounced value differs from the stored previous value, status bit 8 is set and the stored value takes the debounced value at the same edge. While mask bit 8 is 0, the stored value is held. A change that occurred while masked is therefore flagged once the bit is enabled.
- R9: The power-on flag is 1 after reset. It becomes 0 at the edge where `cfg_exit` is 1.
- R10: If a clear of a status bit and a set condition for that bit fall on the same edge, the bit ends at 1.
- R11: Writes to address 0 change neither the mask nor the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ssa_any | input | 1 | Any safety-status-A flag set |
| ssb_any | input | 1 | Any safety-status-B flag set |
| saa_any | input | 1 | Any safety-alert-A flag set |
| sab_any | input | 1 | Any safety-alert-B flag set |
| chg_off | input | 1 | Charge switch is off |
| dsg_off | input | 1 | Discharge switch is off |
| shut_low | input | 1 | Stack or cell voltage below shutdown level |
| init_done | input | 1 | One-cycle pulse at end of startup evaluation |
| chg_det | input | 1 | Charger-detect comparator output |
| cfg_exit | input | 1 | Pulse when configuration-update mode ends |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | 2 | Register select: 0 raw, 1 status, 2 mask |
| wr_data | input | 10 | Write data |
| rd_data | output | 10 | Read data of addressed register |
| alert_n | output | 1 | Active-low interrupt, pull-low request |

## Verification
The bench builds the block with `DEB_N` = 4, so debounce windows that are too short and windows that are long enough both fit in a few cycles. It uses `DEF_MASK` = 10'h1FF, which leaves the power-on bit masked out of reset. That makes masked suppression visible straight after reset. Enabling the power-on bit later then shows a held raw level being captured.

// File: rtl/alarm_agg.sv
module alarm_agg #(
  parameter int          DEB_N    = 16,
  parameter logic [9:0]  DEF_MASK = 10'h3FF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ssa_any,
  input  logic       ssb_any,
  input  logic       saa_any,
  input  logic       sab_any,
  input  logic       chg_off,
  input  logic       dsg_off,
  input  logic       shut_low,
  input  logic       init_done,
  input  logic       chg_det,
  input  logic       cfg_exit,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [9:0] wr_data,
  output logic [9:0] rd_data,
  output logic       alert_n
);
  localparam int CW = $clog2(DEB_N + 1);
  localparam logic [CW-1:0] CLAST = CW'(DEB_N - 1);

  logic [9:0]    status, mask, raw, set_v, clr_v;
  logic          por_flag, deb, prev, tog;
  logic [CW-1:0] cnt;

  assign raw   = {por_flag, chg_det, init_done, shut_low, dsg_off, chg_off,
                  sab_any, saa_any, ssb_any, ssa_any};
  assign tog   = deb ^ prev;
  assign set_v = {raw[9] & mask[9], mask[8] & tog, raw[7:0] & mask[7:0]};
  assign clr_v = (wr_en && addr == 2'd1) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= '0;
      mask     <= DEF_MASK;
      por_flag <= 1'b1;
      deb      <= 1'b0;
      prev     <= 1'b0;
      cnt      <= '0;
    end else begin
      status <= (status & ~clr_v) | set_v;
      if (wr_en && addr == 2'd2) mask <= wr_data;
      if (cfg_exit) por_flag <= 1'b0;
      if (mask[8] && tog) prev <= deb;
      if (chg_det == deb) cnt <= '0;
      else if (cnt == CLAST) begin
        deb <= chg_det;
        cnt <= '0;
      end else cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rd_data = raw;
      2'd1:    rd_data = status;
      2'd2:    rd_data = mask;
      default: rd_data = '0;
    endcase
  end

  assign alert_n = ~|status;

  for (genvar k = 0; k < 10; k++) begin : g_chk
    if (k != 8) begin : g_lvl
      // R2 R10
      level_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(raw[k] && mask[k]) |-> status[k]);
      // R2
      rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(status[k]) |-> $past(raw[k] && mask[k]));
    end
  end

  // R8
  toggle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $rose(status[8]) |-> $past(mask[8] && (deb != prev)));

  // R8
  prev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(mask[8]) |-> $stable(prev));

  // R7
  deb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && (deb != $past(deb)) |-> $past(chg_det) == deb);

  // R4 R11
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(wr_en && addr == 2'd2) |-> $stable(mask));

  // R9
  por_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $fell(por_flag) |-> $past(cfg_exit));
endmodule

// File: tb/alarm_agg_tb_top.sv
module alarm_agg_tb_top;
  localparam int N   = 4;
  localparam int DEF = 'h1FF;

  logic clk = 0;
  logic rst_n = 0;
  logic ssa_any = 0, ssb_any = 0, saa_any = 0, sab_any = 0;
  logic chg_off = 0, dsg_off = 0, shut_low = 0, init_done = 0;
  logic chg_det = 0, cfg_exit = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [9:0] wr_data = 0;
  logic [9:0] rd_data;
  logic alert_n;

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit running = 0;
  string cur_req = "R1";

  int m_st, m_mk, m_deb, m_prev, m_cnt, m_por;

  always #10 clk = ~clk;

  alarm_agg #(.DEB_N(N), .DEF_MASK(10'(DEF))) dut_i (
    .clk(clk), .rst_n(rst_n), .ssa_any(ssa_any), .ssb_any(ssb_any),
    .saa_any(saa_any), .sab_any(sab_any), .chg_off(chg_off), .dsg_off(dsg_off),
    .shut_low(shut_low), .init_done(init_done), .chg_det(chg_det),
    .cfg_exit(cfg_exit), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .alert_n(alert_n));

  function automatic int mraw();
    return (int'(m_por) << 9) | (int'(chg_det) << 8) | (int'(init_done) << 7) |
           (int'(shut_low) << 6) | (int'(dsg_off) << 5) | (int'(chg_off) << 4) |
           (int'(sab_any) << 3) | (int'(saa_any) << 2) | (int'(ssb_any) << 1) |
           int'(ssa_any);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_mk = DEF; m_deb = 0; m_prev = 0; m_cnt = 0; m_por = 1;
    end else begin
      int r, s, c, tg;
      r  = mraw();
      tg = (m_deb != m_prev) && m_mk[8];
      s  = r & m_mk & 'h2FF;
      if (tg) s = s | 'h100;
      c  = (wr_en && addr == 1) ? int'(wr_data) : 0;
      if (tg) m_prev = m_deb;
      if (int'(chg_det) == m_deb) m_cnt = 0;
      else if (m_cnt == N - 1) begin m_deb = int'(chg_det); m_cnt = 0; end
      else m_cnt = m_cnt + 1;
      if (wr_en && addr == 2) m_mk = int'(wr_data);
      if (cfg_exit) m_por = 0;
      m_st = ((m_st & ~c) | s) & 'h3FF;
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic compare();
    int e;
    case (addr)
      2'd0: e = mraw();
      2'd1: e = m_st;
      2'd2: e = m_mk;
      default: e = 0;
    endcase
    chk(cur_req, "rd_data", int'(rd_data), e);
    chk("R1", "alert_n", int'(alert_n), (m_st == 0) ? 1 : 0);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (running) compare();
    end
  endtask

  task automatic rd(string req, logic [1:0] a, int exp);
    addr = a;
    #1;
    chk(req, "read", int'(rd_data), exp);
  endtask

  task automatic wr(logic [1:0] a, int d);
    wr_en = 1; addr = a; wr_data = 10'(d);
    step(1);
    wr_en = 0; wr_data = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got %0d expected below 5000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    running = 1;
    step(1);
    cur_req = "R4";
    rd("R4", 2, DEF);
    rd("R1", 1, 0);
    chk("R1", "alert_n after reset", int'(alert_n), 1);
    rd("R9", 0, 'h200);

    cur_req = "R2";
    addr = 1; ssa_any = 1; sab_any = 1;
    step(1);
    ssa_any = 0; sab_any = 0;
    rd("R2", 1, 'h009);
    chk("R1", "alert_n asserted", int'(alert_n), 0);

    cur_req = "R3";
    wr(1, 'h001);
    rd("R3", 1, 'h008);
    wr(1, 'h3F7);
    rd("R3", 1, 'h008);
    wr(1, 'h008);
    rd("R3", 1, 0);
    chk("R1", "alert_n released", int'(alert_n), 1);

    cur_req = "R10";
    chg_off = 1; dsg_off = 1; shut_low = 1;
    step(1);
    wr(1, 'h070);
    rd("R10", 1, 'h070);
    chg_off = 0; dsg_off = 0; shut_low = 0;
    wr(1, 'h070);
    rd("R10", 1, 0);

    cur_req = "R6";
    init_done = 1;
    step(1);
    init_done = 0;
    step(4);
    rd("R6", 1, 'h080);
    rd("R6", 0, 'h200);
    wr(1, 'h080);

    cur_req = "R7";
    chg_det = 1;
    step(N - 1);
    chg_det = 0;
    step(3);
    rd("R7", 1, 0);
    cur_req = "R8";
    chg_det = 1;
    step(N + 2);
    rd("R8", 1, 'h100);
    rd("R8", 0, 'h300);
    wr(1, 'h100);
    step(2);
    rd("R8", 1, 0);
    chg_det = 0;
    step(N + 2);
    rd("R8", 1, 'h100);
    wr(1, 'h100);

    cur_req = "R4";
    wr(2, 'h0FF);
    rd("R4", 2, 'h0FF);
    cur_req = "R8";
    chg_det = 1;
    step(N + 3);
    rd("R8", 1, 0);
    wr(2, 'h1FF);
    step(1);
    rd("R8", 1, 'h100);
    wr(1, 'h100);

    cur_req = "R2";
    wr(2, 'h000);
    ssb_any = 1; saa_any = 1;
    step(3);
    rd("R2", 1, 0);
    ssb_any = 0; saa_any = 0;

    cur_req = "R9";
    wr(2, 'h200);
    step(1);
    rd("R9", 1, 'h200);
    cfg_exit = 1;
    step(1);
    cfg_exit = 0;
    rd("R9", 0, 'h100);
    wr(1, 'h200);
    step(2);
    rd("R9", 1, 0);

    cur_req = "R11";
    ssa_any = 1;
    wr(2, 'h001);
    step(1);
    ssa_any = 0;
    wr(0, 'h3FE);
    step(1);
    rd("R11", 2, 'h001);
    rd("R11", 1, 'h001);

    cur_req = "R5";
    rd("R5", 3, 0);
    step(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule